// File: doc/BRIEF.md
# Guarded Watchdog-Period Control Register

This block keeps an 8-bit control register for a supply and watchdog supervisor. The register holds two volatile enable latches and a 2-bit watchdog period selection that stands for persistent storage. A serial bus front end decodes each complete single-byte register write and passes it in as a one-cycle strobe with its data byte. The block decides whether the write is allowed, updates the latches or the period bits, and answers with a registered response that the front end turns into its acknowledge bit.

The period bits change only at the end of a three-write unlock sequence. The first write arms the write-enable latch. The second write arms the register-write latch. The third write carries the new period. A period store starts a busy window of a set number of clock ticks, which stands in for the persistent write cycle. No write is taken while that window is open. A high write-protect pin blocks every write and also disarms the register-write latch. The register can be read at any time, and reading it does not disturb the unlock sequence.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After reset `reg_value` reads 8'h60, `wd_sel` is 2'b11 and `nv_busy` is low. The register is laid out as {0, WD[1:0], 0, 0, REGEN, WREN, 0}, with REGEN at bit 2 and WREN at bit 1.
- R2: Each write strobe produces `resp_valid` high for exactly one cycle, in the cycle after the clock edge that samples the strobe. In that cycle `resp_ok` shows whether the write was accepted. A cycle with no strobe gives `resp_valid` low and `resp_ok` low.
- R3: While WREN is 0, every write other than 8'h02 is rejected and leaves the register unchanged.
- R4: Writing 8'h02 while REGEN is 0 is accepted and sets WREN. Writing 8'h06 while WREN is 1 and REGEN is 0 is accepted and sets REGEN. Neither write raises `nv_busy`.
- R5: With WREN and REGEN both 1, a write of the form 0xy0_0010 is accepted. It stores xy into WD[1:0], clears REGEN and raises `nv_busy`. The sequence 02h, 06h, 02h therefore leaves WD at 00.
- R6: With WREN and REGEN both 1, a write of the form 0xy0_0110 is accepted and leaves WD, REGEN and WREN unchanged. The sequence 02h, 06h, 06h therefore keeps the old WD value with REGEN still 1.
- R7: Writing 8'h00 while WREN is 1 is accepted, clears WREN and does not raise `nv_busy`.
- R8: While `wp_pin` is high every write is rejected. Such a write clears REGEN and leaves WREN and WD unchanged.
- R9: A period store holds `nv_busy` high for exactly BUSY_TICKS cycles. Any write made while `nv_busy` is high is rejected and changes nothing.
- R10: A byte with bit 7, 4, 3 or 0 set, a byte with bits 2:1 equal to 10, or a byte with bits 2:1 equal to 00 and nonzero bits 6:5, is rejected and changes nothing.
- R11: With no write strobe, `reg_value` holds its value from cycle to cycle, so reads between unlock steps leave the sequence intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_stb | input | 1 | One-cycle strobe for a completed register write |
| wr_data | input | 8 | Data byte of the write |
| wp_pin | input | 1 | Write-protect pin, active high |
| reg_value | output | 8 | Current register read value |
| wd_sel | output | 2 | Watchdog period selection bits |
| nv_busy | output | 1 | High during the emulated persistent write window |
| resp_valid | output | 1 | Response to a strobe is present this cycle |
| resp_ok | output | 1 | The write was accepted (acknowledge) |

## Verification
The three-step unlock is driven with each of its possible third bytes. A store byte shows that the period is written and the register-write latch drops. A keep byte shows that both latches survive and the period is untouched. The pair 02h,06h,02h against 02h,06h,06h separates a store of 00 from a no-op. Each unlock step is also tried out of order, with protect high, during the busy window and with malformed bytes, which confirms that every guard on its own both rejects the write and preserves the state. Finally, idle stretches between the steps show that plain reads cannot break a partly completed sequence.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [1:0] {
    PAT_CLEAR = 2'd0,
    PAT_STORE = 2'd1,
    PAT_KEEP  = 2'd2,
    PAT_BAD   = 2'd3
  } pat_e;

  localparam int REG_W = 8;
  localparam int WD_W  = 2;

  // Sort a written byte into one of the defined write forms.
  function automatic pat_e classify(input logic [REG_W-1:0] d);
    pat_e p;
    if (d[7] | d[4] | d[3] | d[0]) begin
      p = PAT_BAD;
    end else begin
      case (d[2:1])
        2'b01:   p = PAT_STORE;
        2'b11:   p = PAT_KEEP;
        2'b00:   p = (d[6:5] == 2'b00) ? PAT_CLEAR : PAT_BAD;
        default: p = PAT_BAD;
      endcase
    end
    return p;
  endfunction

  // Assemble the read value from the stored fields.
  function automatic logic [REG_W-1:0] pack_reg(input logic [WD_W-1:0] wd,
                                                input logic regen,
                                                input logic wren);
    return {1'b0, wd, 2'b00, regen, wren, 1'b0};
  endfunction

endpackage

// File: rtl/ctlreg_decide.sv
module ctlreg_decide
  import ctlreg_pkg::*;
(
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wp_pin,
  input  logic             busy,
  input  logic             wren,
  input  logic             regen,
  output logic             take,
  output logic             wren_nx,
  output logic             regen_nx,
  output logic             store_go
);

  pat_e pat;
  logic xy_zero;

  assign pat     = classify(wr_data);
  assign xy_zero = (wr_data[6:5] == 2'b00);

  always_comb begin
    take     = 1'b0;
    wren_nx  = wren;
    regen_nx = regen;
    store_go = 1'b0;
    if (wr_stb && !busy) begin
      if (wp_pin) begin
        regen_nx = 1'b0;
      end else begin
        case (pat)
          PAT_CLEAR: begin
            if (wren) begin
              take    = 1'b1;
              wren_nx = 1'b0;
            end
          end
          PAT_STORE: begin
            if (wren && regen) begin
              take     = 1'b1;
              store_go = 1'b1;
              regen_nx = 1'b0;
            end else if (xy_zero) begin
              take    = 1'b1;
              wren_nx = 1'b1;
            end
          end
          PAT_KEEP: begin
            if (wren && regen) begin
              take = 1'b1;
            end else if (wren && xy_zero) begin
              take     = 1'b1;
              regen_nx = 1'b1;
            end
          end
          default: begin
            take = 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ctlreg_busy.sv
module ctlreg_busy #(
  parameter int BUSY_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(BUSY_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg
  import ctlreg_pkg::*;
#(
  parameter int              BUSY_TICKS = 16,
  parameter logic [WD_W-1:0] WD_INIT    = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wp_pin,
  output logic [REG_W-1:0] reg_value,
  output logic [WD_W-1:0]  wd_sel,
  output logic             nv_busy,
  output logic             resp_valid,
  output logic             resp_ok
);

  logic            wren_q, regen_q;
  logic [WD_W-1:0] wd_q;
  logic            take, wren_nx, regen_nx, store_go;

  ctlreg_decide u_decide (
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .wp_pin   (wp_pin),
    .busy     (nv_busy),
    .wren     (wren_q),
    .regen    (regen_q),
    .take     (take),
    .wren_nx  (wren_nx),
    .regen_nx (regen_nx),
    .store_go (store_go)
  );

  ctlreg_busy #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (store_go),
    .busy  (nv_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q     <= 1'b0;
      regen_q    <= 1'b0;
      wd_q       <= WD_INIT;
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
    end else begin
      wren_q     <= wren_nx;
      regen_q    <= regen_nx;
      resp_valid <= wr_stb;
      resp_ok    <= take;
      if (store_go) wd_q <= wr_data[6:5];
    end
  end

  assign wd_sel    = wd_q;
  assign reg_value = pack_reg(wd_q, regen_q, wren_q);

endmodule

// File: rtl/guarded_ctrl_reg_chk.sv
module guarded_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       wp_pin,
  input logic [7:0] reg_value,
  input logic [1:0] wd_sel,
  input logic       nv_busy,
  input logic       resp_valid,
  input logic       resp_ok
);

  // R2
  resp_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> resp_valid);

  // R2
  no_stray_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (!resp_valid && !resp_ok));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && nv_busy) |=> (!resp_ok && $stable(reg_value)));

  // R8
  protect_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wp_pin && !nv_busy) |=> (!resp_ok && !reg_value[2]));

  // R5
  wd_change_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_sel) |-> (resp_ok && nv_busy));

  // R5
  busy_start_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> resp_ok);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(reg_value));

endmodule

bind guarded_ctrl_reg guarded_ctrl_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .wp_pin     (wp_pin),
  .reg_value  (reg_value),
  .wd_sel     (wd_sel),
  .nv_busy    (nv_busy),
  .resp_valid (resp_valid),
  .resp_ok    (resp_ok)
);

// File: tb/guarded_ctrl_reg_test.sv
`timescale 1ns/1ps
module guarded_ctrl_reg_test;

  localparam int TICKS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wp_pin = 1'b0;
  logic [7:0] reg_value;
  logic [1:0] wd_sel;
  logic       nv_busy, resp_valid, resp_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  guarded_ctrl_reg #(.BUSY_TICKS(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .wp_pin(wp_pin), .reg_value(reg_value), .wd_sel(wd_sel),
    .nv_busy(nv_busy), .resp_valid(resp_valid), .resp_ok(resp_ok)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // One write; returns at the negedge where the response is visible.
  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic put_chk(input string req, input logic [7:0] d,
                         input logic ok, input logic [7:0] exp_reg);
    put(d);
    check({req, " resp_valid"}, 32'(resp_valid), 32'd1);
    check({req, " resp_ok"}, 32'(resp_ok), 32'(ok));
    check({req, " reg_value"}, 32'(reg_value), 32'(exp_reg));
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reg", 32'(reg_value), 32'h60);
    check("R1 wd", 32'(wd_sel), 32'h3);
    check("R1 busy", 32'(nv_busy), 32'd0);
    @(negedge clk);
    check("R2 no strobe valid", 32'(resp_valid), 32'd0);
    check("R2 no strobe ok", 32'(resp_ok), 32'd0);
  endtask

  task automatic t_locked();
    put_chk("R3 06h locked", 8'h06, 1'b0, 8'h60);
    put_chk("R3 22h locked", 8'h22, 1'b0, 8'h60);
    put_chk("R3 00h locked", 8'h00, 1'b0, 8'h60);
    @(negedge clk);
    check("R2 one cycle", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_unlock_keep();
    put_chk("R4 02h", 8'h02, 1'b1, 8'h62);
    check("R4 no busy", 32'(nv_busy), 32'd0);
    repeat (4) @(negedge clk);
    check("R11 idle hold", 32'(reg_value), 32'h62);
    put_chk("R4 06h", 8'h06, 1'b1, 8'h66);
    check("R4 no busy 2", 32'(nv_busy), 32'd0);
    put_chk("R6 keep 26h", 8'h26, 1'b1, 8'h66);
    put_chk("R6 keep 06h", 8'h06, 1'b1, 8'h66);
    check("R6 wd kept", 32'(wd_sel), 32'h3);
  endtask

  task automatic t_bad();
    put_chk("R10 80h", 8'h80, 1'b0, 8'h66);
    put_chk("R10 01h", 8'h01, 1'b0, 8'h66);
    put_chk("R10 04h", 8'h04, 1'b0, 8'h66);
    put_chk("R10 40h", 8'h40, 1'b0, 8'h66);
    put_chk("R10 0Ah", 8'h0A, 1'b0, 8'h66);
  endtask

  task automatic t_store_busy();
    int n;
    put_chk("R5 store 22h", 8'h22, 1'b1, 8'h22);
    check("R5 wd", 32'(wd_sel), 32'h1);
    check("R5 busy", 32'(nv_busy), 32'd1);
    put_chk("R9 reject 00h busy", 8'h00, 1'b0, 8'h22);
    put_chk("R9 reject 06h busy", 8'h06, 1'b0, 8'h22);
    wait_idle();
    put_chk("R4 06h re-arm", 8'h06, 1'b1, 8'h26);
    put_chk("R5 store 42h", 8'h42, 1'b1, 8'h42);
    n = 0;
    while (nv_busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R9 busy length", 32'(n), 32'(TICKS));
  endtask

  task automatic t_clear();
    put_chk("R7 00h", 8'h00, 1'b1, 8'h40);
    check("R7 no busy", 32'(nv_busy), 32'd0);
    put_chk("R7 00h again", 8'h00, 1'b0, 8'h40);
  endtask

  task automatic t_protect();
    put_chk("R4 02h", 8'h02, 1'b1, 8'h42);
    put_chk("R4 06h", 8'h06, 1'b1, 8'h46);
    wp_pin = 1'b1;
    put_chk("R8 wp 02h", 8'h02, 1'b0, 8'h42);
    put_chk("R8 wp 06h", 8'h06, 1'b0, 8'h42);
    wp_pin = 1'b0;
    put_chk("R8 after wp 22h", 8'h22, 1'b0, 8'h42);
    check("R8 wd", 32'(wd_sel), 32'h2);
  endtask

  task automatic t_zero_store();
    put_chk("R4 06h", 8'h06, 1'b1, 8'h46);
    put_chk("R5 02h store 00", 8'h02, 1'b1, 8'h02);
    check("R5 wd zero", 32'(wd_sel), 32'h0);
    wait_idle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock_keep();
    t_bad();
    t_store_busy();
    t_clear();
    t_protect();
    t_zero_store();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule